// File: doc/BRIEF.md
# Register Hazard Scoreboard with Reader Counts

This block is the central hazard checker for a single-issue core that schedules work dynamically. Each cycle the decoder presents one instruction: up to two source registers and an optional destination. The scoreboard answers at once whether that instruction may leave decode. It returns one stall signal and a four-bit vector of hazard causes. The causes are:

- a read-after-write hazard;
- a write-after-write hazard;
- a write-after-read hazard;
- a reader counter that has run out of room.

Two kinds of state stand behind the answer. Each register has a pending-write flag. Each register also has a counter of readers that have decoded but not yet issued. A later write can therefore be held back while older readers still need the old value, with no renaming. An accepted decode claims its destination and adds its readers. Issue events then remove the readers, and writeback events release the destination. A writeback that arrives in the same cycle as a decode is seen by that decode's hazard check.

Top module: `regScoreboard`

## Requirements
- R1: After reset every register is free and has no outstanding readers, so any decode is accepted.
- R2: Hazard bit 0 (RAW) is set when a source whose use flag is high names a register with a pending write. A source whose use flag is low is ignored.
- R3: Hazard bit 1 (WAW) is set when a decode with a destination names a register that already has a pending write.
- R4: Hazard bit 2 (WAR) is set when a decode with a destination names a register whose reader count is nonzero.
- R5: Hazard bit 3 (capacity) is set when accepting the decode would push a source register's reader count above 2^CNT_W-1. A register named by both sources adds two.
- R6: The stall output is the OR of the four hazard bits. All hazard bits are 0 whenever the decode valid input is low.
- R7: An accepted decode (valid and not stalled) marks its destination pending and adds one reader per used source, two for a register named twice. A stalled decode changes no state.
- R8: An issue event removes one reader per flagged source, two for a register named twice. The counts return exactly to zero once every reader has issued.
- R9: A writeback frees its register and is already visible to a decode check in the same cycle. If that decode claims the same register, the register ends the cycle pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | An instruction is presented at decode |
| decUseA | input | 1 | First source is read |
| decSrcA | input | IDX_W | First source register |
| decUseB | input | 1 | Second source is read |
| decSrcB | input | IDX_W | Second source register |
| decHasTgt | input | 1 | Instruction writes a destination |
| decTgt | input | IDX_W | Destination register |
| issValid | input | 1 | An instruction issues this cycle |
| issUseA | input | 1 | Issuing instruction read its first source |
| issSrcA | input | IDX_W | First source of the issuing instruction |
| issUseB | input | 1 | Issuing instruction read its second source |
| issSrcB | input | IDX_W | Second source of the issuing instruction |
| wbValid | input | 1 | A result is written back this cycle |
| wbTgt | input | IDX_W | Register being written back |
| decStall | output | 1 | Decode must hold this instruction |
| decHazard | output | 4 | Causes: bit0 RAW, bit1 WAW, bit2 WAR, bit3 counter capacity |

## Verification
The hardest state to reach from the ports is a reader counter at its ceiling while the same register also has a pending write and a writeback or issue lands in that very cycle. Only then do the capacity check, the WAR check and the writeback bypass all decide one outcome together. The bench uses a small configuration with 8 registers and 2-bit counters, so the ceiling is three readers. Directed sweeps pile repeated and doubled reads onto one register. A long pseudo-random phase then mixes decode, legal issue and legal writeback events each cycle, checked against a reference model that tracks flags and counts.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // hazard cause positions in the decode hazard vector
  localparam int HZ_RAW  = 0;
  localparam int HZ_WAW  = 1;
  localparam int HZ_WAR  = 2;
  localparam int HZ_FULL = 3;
  localparam int HZ_W    = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic claimTgt;  // accepted decode marks its destination pending
    logic readA;     // accepted decode adds a reader on source A
    logic readB;     // accepted decode adds a reader on source B
    logic dropA;     // issue removes a reader from source A
    logic dropB;     // issue removes a reader from source B
    logic fillTgt;   // writeback frees its register
  } sbStrobe_t;

endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 3,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sbStrobe_t                 st,
  input  logic [IDX_W-1:0]          decSrcA,
  input  logic [IDX_W-1:0]          decSrcB,
  input  logic [IDX_W-1:0]          decTgt,
  input  logic [IDX_W-1:0]          issSrcA,
  input  logic [IDX_W-1:0]          issSrcB,
  input  logic [IDX_W-1:0]          wbTgt,
  output logic [NUM_REGS-1:0]       availVec,
  output logic [NUM_REGS*CNT_W-1:0] readCnt
);

  localparam int WIDE_W = CNT_W + 2;
  localparam logic [WIDE_W-1:0] CNT_MAX = WIDE_W'((1 << CNT_W) - 1);

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);

    logic             availQ;
    logic             availD;
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] cntD;
    logic [1:0]       incR;
    logic [1:0]       decR;
    logic [WIDE_W-1:0] cntWide;
    logic             hitFill;
    logic             hitClaim;

    assign hitFill  = st.fillTgt  && (wbTgt  == MY_IDX);
    assign hitClaim = st.claimTgt && (decTgt == MY_IDX);

    // writeback first, a same-cycle claim then wins
    always_comb begin
      availD = availQ;
      if (hitFill)  availD = 1'b1;
      if (hitClaim) availD = 1'b0;
    end

    always_comb begin
      incR = 2'({1'b0, st.readA && (decSrcA == MY_IDX)})
           + 2'({1'b0, st.readB && (decSrcB == MY_IDX)});
      decR = 2'({1'b0, st.dropA && (issSrcA == MY_IDX)})
           + 2'({1'b0, st.dropB && (issSrcB == MY_IDX)});
      cntWide = WIDE_W'(cntQ) + WIDE_W'(incR) - WIDE_W'(decR);
      cntD = cntWide[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        availQ <= 1'b1;
        cntQ   <= '0;
      end else begin
        availQ <= availD;
        cntQ   <= cntD;
      end
    end

    assign availVec[r]               = availQ;
    assign readCnt[r*CNT_W +: CNT_W] = cntQ;

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (WIDE_W'(cntQ) + WIDE_W'(incR)) >= WIDE_W'(decR));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (WIDE_W'(cntQ) + WIDE_W'(incR) - WIDE_W'(decR)) <= CNT_MAX);
  end

endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 3,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      decValid,
  input  logic                      decUseA,
  input  logic [IDX_W-1:0]          decSrcA,
  input  logic                      decUseB,
  input  logic [IDX_W-1:0]          decSrcB,
  input  logic                      decHasTgt,
  input  logic [IDX_W-1:0]          decTgt,
  input  logic                      issValid,
  input  logic                      issUseA,
  input  logic                      issUseB,
  input  logic                      wbValid,
  input  logic [IDX_W-1:0]          wbTgt,
  input  logic [NUM_REGS-1:0]       availVec,
  input  logic [NUM_REGS*CNT_W-1:0] readCnt,
  output sbStrobe_t                 st,
  output logic                      decStall,
  output logic [HZ_W-1:0]           decHazard
);

  localparam int WIDE_W = CNT_W + 2;
  localparam logic [WIDE_W-1:0] CNT_MAX = WIDE_W'((1 << CNT_W) - 1);

  logic             freeA;
  logic             freeB;
  logic             freeT;
  logic [CNT_W-1:0] cntA;
  logic [CNT_W-1:0] cntB;
  logic [CNT_W-1:0] cntT;
  logic [1:0]       addA;
  logic [1:0]       addB;
  logic             sameSrc;
  logic             rawHit;
  logic             wawHit;
  logic             warHit;
  logic             fullHit;
  logic             accept;

  // availability with same-cycle writeback bypass
  assign freeA = availVec[decSrcA] || (wbValid && (wbTgt == decSrcA));
  assign freeB = availVec[decSrcB] || (wbValid && (wbTgt == decSrcB));
  assign freeT = availVec[decTgt]  || (wbValid && (wbTgt == decTgt));

  assign cntA = readCnt[decSrcA*CNT_W +: CNT_W];
  assign cntB = readCnt[decSrcB*CNT_W +: CNT_W];
  assign cntT = readCnt[decTgt*CNT_W +: CNT_W];

  assign sameSrc = decUseA && decUseB && (decSrcA == decSrcB);
  assign addA    = 2'({1'b0, decUseA}) + 2'({1'b0, sameSrc});
  assign addB    = 2'({1'b0, decUseB}) + 2'({1'b0, sameSrc});

  always_comb begin
    rawHit  = (decUseA && !freeA) || (decUseB && !freeB);
    wawHit  = decHasTgt && !freeT;
    warHit  = decHasTgt && (cntT != '0);
    fullHit = (decUseA && ((WIDE_W'(cntA) + WIDE_W'(addA)) > CNT_MAX))
           || (decUseB && ((WIDE_W'(cntB) + WIDE_W'(addB)) > CNT_MAX));
  end

  always_comb begin
    decHazard          = '0;
    decHazard[HZ_RAW]  = decValid && rawHit;
    decHazard[HZ_WAW]  = decValid && wawHit;
    decHazard[HZ_WAR]  = decValid && warHit;
    decHazard[HZ_FULL] = decValid && fullHit;
  end

  assign decStall = |decHazard;
  assign accept   = decValid && !decStall;

  always_comb begin
    st          = '0;
    st.claimTgt = accept && decHasTgt;
    st.readA    = accept && decUseA;
    st.readB    = accept && decUseB;
    st.dropA    = issValid && issUseA;
    st.dropB    = issValid && issUseB;
    st.fillTgt  = wbValid;
  end

  // R7
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.claimTgt |=> !availVec[$past(decTgt)]);

  // R9
  fill_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.fillTgt && !(st.claimTgt && (decTgt == wbTgt))) |=> availVec[$past(wbTgt)]);

endmodule

// File: rtl/regScoreboard.sv
module regScoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 3,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic             decUseA,
  input  logic [IDX_W-1:0] decSrcA,
  input  logic             decUseB,
  input  logic [IDX_W-1:0] decSrcB,
  input  logic             decHasTgt,
  input  logic [IDX_W-1:0] decTgt,
  input  logic             issValid,
  input  logic             issUseA,
  input  logic [IDX_W-1:0] issSrcA,
  input  logic             issUseB,
  input  logic [IDX_W-1:0] issSrcB,
  input  logic             wbValid,
  input  logic [IDX_W-1:0] wbTgt,
  output logic             decStall,
  output logic [3:0]       decHazard
);

  sbStrobe_t                 st;
  logic [NUM_REGS-1:0]       availVec;
  logic [NUM_REGS*CNT_W-1:0] readCnt;

  sb_control #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decUseA(decUseA), .decSrcA(decSrcA),
    .decUseB(decUseB), .decSrcB(decSrcB),
    .decHasTgt(decHasTgt), .decTgt(decTgt),
    .issValid(issValid), .issUseA(issUseA), .issUseB(issUseB),
    .wbValid(wbValid), .wbTgt(wbTgt),
    .availVec(availVec), .readCnt(readCnt),
    .st(st), .decStall(decStall), .decHazard(decHazard)
  );

  sb_datapath #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .decSrcA(decSrcA), .decSrcB(decSrcB), .decTgt(decTgt),
    .issSrcA(issSrcA), .issSrcB(issSrcB), .wbTgt(wbTgt),
    .availVec(availVec), .readCnt(readCnt)
  );

endmodule

// File: tb/regScoreboard_test.sv
`timescale 1ns/1ps
module regScoreboard_test;

  localparam int NR   = 8;
  localparam int CW   = 2;
  localparam int IW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 0, decUseA = 0, decUseB = 0, decHasTgt = 0;
  logic [IW-1:0] decSrcA = 0, decSrcB = 0, decTgt = 0;
  logic issValid = 0, issUseA = 0, issUseB = 0;
  logic [IW-1:0] issSrcA = 0, issSrcB = 0;
  logic wbValid = 0;
  logic [IW-1:0] wbTgt = 0;
  logic decStall;
  logic [3:0] decHazard;

  int nChecks = 0;
  int nFails  = 0;
  int mAvail [NR];
  int mCnt   [NR];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  regScoreboard #(.NUM_REGS(NR), .CNT_W(CW), .IDX_W(IW)) uut (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decUseA(decUseA), .decSrcA(decSrcA),
    .decUseB(decUseB), .decSrcB(decSrcB),
    .decHasTgt(decHasTgt), .decTgt(decTgt),
    .issValid(issValid), .issUseA(issUseA), .issSrcA(issSrcA),
    .issUseB(issUseB), .issSrcB(issSrcB),
    .wbValid(wbValid), .wbTgt(wbTgt),
    .decStall(decStall), .decHazard(decHazard)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    finishRun();
  end

  task automatic idle();
    decValid = 0; decUseA = 0; decUseB = 0; decHasTgt = 0;
    decSrcA = 0; decSrcB = 0; decTgt = 0;
    issValid = 0; issUseA = 0; issUseB = 0; issSrcA = 0; issSrcB = 0;
    wbValid = 0; wbTgt = 0;
  endtask

  task automatic setDec(input logic ua, input int sa, input logic ub, input int sb,
                        input logic ht, input int t);
    decValid = 1; decUseA = ua; decSrcA = IW'(sa); decUseB = ub; decSrcB = IW'(sb);
    decHasTgt = ht; decTgt = IW'(t);
  endtask

  task automatic setIss(input logic ua, input int sa, input logic ub, input int sb);
    issValid = 1; issUseA = ua; issSrcA = IW'(sa); issUseB = ub; issSrcB = IW'(sb);
  endtask

  task automatic setWb(input int t);
    wbValid = 1; wbTgt = IW'(t);
  endtask

  // inputs are set after a falling edge; check, clock, update model, clear
  task automatic step(input string tag);
    int effA, effB, effT, incA, incB, sa, sb, t;
    logic [3:0] expHz;
    logic expStall;
    #1;
    sa = int'(decSrcA); sb = int'(decSrcB); t = int'(decTgt);
    effA = mAvail[sa] | ((wbValid && wbTgt == decSrcA) ? 1 : 0);
    effB = mAvail[sb] | ((wbValid && wbTgt == decSrcB) ? 1 : 0);
    effT = mAvail[t]  | ((wbValid && wbTgt == decTgt)  ? 1 : 0);
    incA = int'(decUseA) + ((decUseA && decUseB && sa == sb) ? 1 : 0);
    incB = int'(decUseB) + ((decUseA && decUseB && sa == sb) ? 1 : 0);
    expHz = '0;
    if (decValid) begin
      expHz[0] = (decUseA && effA == 0) || (decUseB && effB == 0);
      expHz[1] = decHasTgt && effT == 0;
      expHz[2] = decHasTgt && mCnt[t] != 0;
      expHz[3] = (decUseA && mCnt[sa] + incA > CMAX) || (decUseB && mCnt[sb] + incB > CMAX);
    end
    expStall = |expHz;
    nChecks++;
    if (decHazard !== expHz || decStall !== expStall) begin
      nFails++;
      $display("FAIL %s: hazard/stall actual %b/%b expected %b/%b", tag,
               decHazard, decStall, expHz, expStall);
    end
    @(posedge clk);
    if (wbValid) mAvail[int'(wbTgt)] = 1;
    if (decValid && !expStall) begin
      if (decHasTgt) mAvail[t] = 0;
      if (decUseA) mCnt[sa]++;
      if (decUseB) mCnt[sb]++;
    end
    if (issValid) begin
      if (issUseA) mCnt[int'(issSrcA)]--;
      if (issUseB) mCnt[int'(issSrcB)]--;
    end
    @(negedge clk);
    idle();
  endtask

  function automatic logic [15:0] nextRand(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    for (int i = 0; i < NR; i++) begin mAvail[i] = 1; mCnt[i] = 0; end
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R6: quiet port after reset, then every register accepted
    step("R6 idle");
    for (int r = 0; r < NR; r++) begin
      setDec(1, r, 0, 0, 1, r); step("R1 reset free");
      setDec(1, r, 0, 0, 1, r); step("R7 claim+read");
      setDec(0, 0, 0, 0, 0, 0); decValid = 0; decUseA = 1; decSrcA = IW'(r);
      decHasTgt = 1; decTgt = IW'(r); step("R6 valid low");
      setIss(1, r, 0, 0); setWb(r); step("R8 R9 drain");
    end

    // R2 / R3: exhaustive producer-consumer pairs
    for (int p = 0; p < NR; p++) begin
      for (int c = 0; c < NR; c++) begin
        setDec(0, 0, 0, 0, 1, p);        step("R7 claim");
        setDec(0, c, 1, c, 0, 0);        step("R2 raw srcB");
        setDec(0, p, 0, p, 1, c);        step("R3 waw / R2 unused");
        if (c != p && mCnt[c] != 0) begin setIss(0, 0, 1, c); step("R8 drop"); end
        if (mCnt[c] != 0) begin setIss(0, 0, 1, c); step("R8 drop"); end
        setWb(p); step("R9 free");
        if (mAvail[c] == 0) begin setWb(c); step("R9 free"); end
      end
    end

    // R9: same-cycle writeback bypass and claim-wins
    for (int r = 0; r < NR; r++) begin
      setDec(0, 0, 0, 0, 1, r); step("R7 claim");
      setDec(1, r, 0, 0, 0, 0); setWb(r); step("R9 bypass read");
      setIss(1, r, 0, 0); setDec(0, 0, 0, 0, 1, r); step("R7 reclaim");
      setDec(0, 0, 0, 0, 1, r); setWb(r); step("R9 bypass claim");
      setDec(0, 0, 1, r, 0, 0); step("R9 claim wins");
      setWb(r); step("R9 free");
    end

    // R4 / R5 / R8: reader counting with doubled reads up to the ceiling
    for (int r = 0; r < NR; r++) begin
      setDec(1, r, 1, r, 0, 0); step("R7 double read");
      setDec(0, 0, 0, 0, 1, r); step("R4 war");
      setDec(1, r, 1, r, 0, 0); step("R5 full double");
      setDec(1, r, 0, 0, 0, 0); step("R7 third reader");
      setDec(0, 0, 1, r, 0, 0); step("R5 full single");
      setIss(1, r, 1, r); step("R8 double drop");
      setDec(0, 0, 0, 0, 1, r); step("R4 war one left");
      setIss(1, r, 0, 0); step("R8 last drop");
      setDec(0, 0, 0, 0, 1, r); step("R8 back to zero");
      setWb(r); step("R9 free");
    end

    // mixed pseudo-random traffic with legal issue and writeback
    for (int k = 0; k < 3000; k++) begin
      int ia, ib, w;
      lfsr = nextRand(lfsr);
      if (lfsr[0]) setDec(lfsr[1], int'(lfsr[4:2]), lfsr[5], int'(lfsr[8:6]),
                          lfsr[9], int'(lfsr[12:10]));
      lfsr = nextRand(lfsr); lfsr = nextRand(lfsr); lfsr = nextRand(lfsr);
      ia = int'(lfsr[2:0]); ib = int'(lfsr[5:3]); w = int'(lfsr[8:6]);
      if (lfsr[9] && mCnt[ia] > 0) begin
        setIss(1, ia, 0, 0);
        if (lfsr[10] && (ib != ia ? mCnt[ib] > 0 : mCnt[ia] > 1)) begin
          issUseB = 1; issSrcB = IW'(ib);
        end
      end
      if (lfsr[11] && mAvail[w] == 0) setWb(w);
      step("R7 R8 R9 mixed");
    end

    finishRun();
  end

endmodule